// File: doc/BRIEF.md
# Digit-Serial Decimal Adder

This block adds two decimal numbers of any length. It takes one digit of each number per clock cycle, starting with the least significant digit. Each digit is a 4-bit BCD code. In every cycle the block returns one sum digit. Between cycles it keeps only a single decimal carry bit. Adding two N-digit numbers therefore takes N cycles. After the last digit, the stored carry gives the extra leading digit of the result.

The sum digit is Mealy-style. It is formed combinationally from the current operand digits and the carry that was stored on an earlier edge. The carry register moves only on a rising clock edge, and only for a valid digit pair. A start pulse marks the first digit pair of a new addition. In that cycle the stored carry is not used, so stale state from the previous addition cannot leak in.

A BCD code above nine on either operand is an error. The block flags it for that cycle, shows a zero sum digit and leaves the carry alone. An upstream controller can then abort or retry the addition.

Top module: `dec_serial_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the stored carry is cleared, so `carry_o` reads 0 after that edge. Reset takes precedence over every other input.
- R2: When both operand digits are 9 or less, `sum_dig_o` equals (a + b + c) mod 10 in the same cycle. Here c is `carry_o`, or 0 when `start_i` is high.
- R3: For a valid pair of legal digits, `carry_o` after the next rising edge is 1 if a + b + c is 10 or more, and 0 otherwise. c is defined as in R2.
- R4: While `valid_i` and `start_i` are both low, `carry_o` keeps its value across the edge.
- R5: `start_i` high forces the carry-in of that cycle to 0. If no legal digit pair is consumed in that cycle, `carry_o` reads 0 after the edge.
- R6: If either operand code is 10 to 15, `sum_dig_o` is 0 in that cycle. `err_o` equals `valid_i` in that cycle. The carry is not loaded from the bad pair: it holds, or it clears if `start_i` is high.
- R7: After the N digits of two N-digit numbers have been fed in, `carry_o` is the most significant digit (0 or 1) of the (N+1)-digit sum. The N sum digits seen along the way are the lower digits of that sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | First digit pair of a new addition; carry-in taken as 0 |
| valid_i | input | 1 | Operand digits present this cycle |
| a_dig_i | input | 4 | Operand A digit, BCD |
| b_dig_i | input | 4 | Operand B digit, BCD |
| sum_dig_o | output | 4 | Sum digit, BCD (Mealy) |
| carry_o | output | 1 | Stored decimal carry; carry-out after the last digit |
| err_o | output | 1 | Valid pair holding a non-BCD code |

## Verification
The bench first drives all 256 combinations of the two 4-bit codes with the stored carry at 0, then all 256 again with the carry at 1. This covers every legal sum from 0 to 19, which separates the wrap at exactly ten from the cases below it. It also covers every illegal code, on either operand or both.

Interleaved idle cycles show the difference between holding the carry and clearing it. Start pulses with a carry of 1 pending show that the stored carry is dropped at a start.

Multi-digit additions with ripple-through carries, such as 99999999 + 1, check the N-cycle decimal result and the final carry-out. Mid-run resets check that reset overrides a pending carry.

// File: rtl/dec_serial_pkg.sv
package dec_serial_pkg;
  localparam int RADIX_DEF = 10;

  function automatic int digit_bits(input int radix);
    return $clog2(radix);
  endfunction
endpackage

// File: rtl/dsa_code_guard.sv
module dsa_code_guard #(
  parameter int RADIX = 10,
  localparam int DIG_W = $clog2(RADIX)
) (
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  output logic             bad_o
);
  localparam logic [DIG_W:0] LIMIT = (DIG_W+1)'(RADIX);

  logic a_bad, b_bad;
  always_comb begin
    a_bad = {1'b0, a_i} >= LIMIT;
    b_bad = {1'b0, b_i} >= LIMIT;
    bad_o = a_bad | b_bad;
  end
endmodule

// File: rtl/dsa_digit_sum.sv
module dsa_digit_sum #(
  parameter int RADIX = 10,
  localparam int DIG_W = $clog2(RADIX)
) (
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] sum_o,
  output logic             cout_o
);
  localparam logic [DIG_W:0] RADIX_W = (DIG_W+1)'(RADIX);

  logic [DIG_W:0] raw;
  logic [DIG_W:0] wrapped;

  always_comb begin
    raw     = {1'b0, a_i} + {1'b0, b_i} + {{DIG_W{1'b0}}, cin_i};
    wrapped = raw - RADIX_W;
    cout_o  = raw >= RADIX_W;
    sum_o   = cout_o ? wrapped[DIG_W-1:0] : raw[DIG_W-1:0];
  end

  // R2
  always_comb begin
    if ({1'b0, a_i} < RADIX_W && {1'b0, b_i} < RADIX_W) begin
      sum_range_chk: assert ({1'b0, sum_o} < RADIX_W);
    end
  end
endmodule

// File: rtl/dsa_carry_reg.sv
module dsa_carry_reg (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst)          q_r <= 1'b0;
    else if (load_i)  q_r <= d_i;
    else if (clear_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> !q_o);
endmodule

// File: rtl/dec_serial_adder.sv
module dec_serial_adder #(
  parameter int RADIX = dec_serial_pkg::RADIX_DEF,
  localparam int DIG_W = $clog2(RADIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [DIG_W-1:0] a_dig_i,
  input  logic [DIG_W-1:0] b_dig_i,
  output logic [DIG_W-1:0] sum_dig_o,
  output logic             carry_o,
  output logic             err_o
);
  localparam logic [DIG_W:0] RADIX_W = (DIG_W+1)'(RADIX);

  logic             bad;
  logic             carry_q;
  logic             cin_eff;
  logic [DIG_W-1:0] raw_sum;
  logic             raw_cout;

  dsa_code_guard #(.RADIX(RADIX)) guard_i (
    .a_i   (a_dig_i),
    .b_i   (b_dig_i),
    .bad_o (bad)
  );

  assign cin_eff = start_i ? 1'b0 : carry_q;

  dsa_digit_sum #(.RADIX(RADIX)) sum_i (
    .a_i    (a_dig_i),
    .b_i    (b_dig_i),
    .cin_i  (cin_eff),
    .sum_o  (raw_sum),
    .cout_o (raw_cout)
  );

  dsa_carry_reg carry_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_i),
    .load_i  (valid_i & ~bad),
    .d_i     (raw_cout),
    .q_o     (carry_q)
  );

  assign sum_dig_o = bad ? '0 : raw_sum;
  assign err_o     = valid_i & bad;
  assign carry_o   = carry_q;

  logic [DIG_W:0] port_total;
  assign port_total = {1'b0, a_dig_i} + {1'b0, b_dig_i}
                    + {{DIG_W{1'b0}}, (start_i ? 1'b0 : carry_o)};

  // R3
  carry_set_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !err_o && {1'b0, a_dig_i} < RADIX_W && {1'b0, b_dig_i} < RADIX_W
     && port_total >= RADIX_W) |=> carry_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !start_i) |=> $stable(carry_o));

  // R6
  err_sum_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (sum_dig_o == '0));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> $stable(carry_o));
endmodule

// File: tb/dec_serial_adder_tb_top.sv
`timescale 1ns/1ps
module dec_serial_adder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] a_dig_i = '0;
  logic [3:0] b_dig_i = '0;
  logic [3:0] sum_dig_o;
  logic       carry_o;
  logic       err_o;

  int n_run = 0;
  int n_fail = 0;
  bit mc = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dec_serial_adder #(.RADIX(10)) dut_i (
    .clk, .rst, .start_i, .valid_i, .a_dig_i, .b_dig_i,
    .sum_dig_o, .carry_o, .err_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one digit cycle: checks stored carry, sum and error; updates the model
  task automatic step(input bit s, input bit v, input int a, input int b);
    bit bad;
    int cin, tot;
    @(negedge clk);
    check("R3/R4 carry_o", int'(carry_o), int'(mc));
    start_i = s; valid_i = v; a_dig_i = 4'(a); b_dig_i = 4'(b);
    #2;
    bad = (a > 9) || (b > 9);
    cin = s ? 0 : int'(mc);
    tot = a + b + cin;
    check(bad ? "R6 sum" : "R2 sum", int'(sum_dig_o), bad ? 0 : tot % 10);
    check("R6 err", int'(err_o), (v && bad) ? 1 : 0);
    if (v && !bad) mc = (tot >= 10);
    else if (s)    mc = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 0, 0);
  endtask

  task automatic add_numbers(input longint x, input longint y, input int n);
    longint p = 1, total = x + y;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      step(i == 0, 1'b1, int'((x / p) % 10), int'((y / p) % 10));
      check("R7 digit", int'(sum_dig_o), int'((total / p) % 10));
      p = p * 10;
    end
    @(negedge clk);
    check("R7 carry-out", int'(carry_o), int'((total / p) % 10));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset carry", int'(carry_o), 0);
    rst = 1'b0;
    mc = 1'b0;

    // exhaustive sweep with stored carry 0 then 1
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          step(1'b1, 1'b1, c ? 9 : 0, c ? 1 : 0);  // R5 start sets up carry
          step(1'b0, 1'b1, a, b);
        end
      end
    end

    // R4: idle holds a carry of 1
    step(1'b1, 1'b1, 9, 9);
    idle(); idle(); idle();
    // R6: bad code does not disturb the carry
    step(1'b0, 1'b1, 12, 3);
    step(1'b0, 1'b0, 15, 15);
    // R5: start alone clears pending carry
    step(1'b1, 1'b0, 0, 0);
    idle();
    // R5: start ignores the pending carry in its own sum
    step(1'b1, 1'b1, 9, 9);
    step(1'b1, 1'b1, 4, 5);
    // R6 with start: bad pair and start clears
    step(1'b1, 1'b1, 9, 9);
    step(1'b1, 1'b1, 10, 0);
    idle();

    // R7: multi-digit additions
    add_numbers(64'd99999999, 64'd1, 8);
    add_numbers(64'd21638753, 64'd73652425, 8);
    add_numbers(64'd12345678, 64'd87654321, 8);
    add_numbers(64'd50000000, 64'd50000000, 8);
    add_numbers(64'd0, 64'd0, 8);
    add_numbers(64'd909, 64'd191, 3);

    // R1: reset overrides a pending carry and a start/valid pair
    step(1'b1, 1'b1, 9, 9);
    @(negedge clk);
    rst = 1'b1; start_i = 1'b1; valid_i = 1'b1; a_dig_i = 4'd9; b_dig_i = 4'd9;
    @(negedge clk);
    check("R1 reset override", int'(carry_o), 0);
    rst = 1'b0; start_i = 1'b0; valid_i = 1'b0;
    mc = 1'b0;
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule